// File: doc/BRIEF.md
# 4B/5B Symbol Codec with Sticky Status

This block sits in the coding layer of a 100 Mb/s physical layer, between the MAC-side nibble path and the 5-bit code-group path. Serialization, scrambling and line coding happen elsewhere. The transmit half takes one nibble per clock together with a frame-enable strobe and an error strobe, and produces one 5-bit code group per clock. It wraps each frame in a two-group start delimiter and a two-group end delimiter. Between frames it sends idle. When the error strobe is raised it sends a halt group in place of the data group.

A configuration input turns error slots into deliberately illegal groups, which is useful for testing a link partner. The receive half sorts every incoming group into one of eight classes: data, idle, the four delimiter symbols, halt, or invalid. It also returns the decoded nibble. Two sticky flags record that an invalid group or a halt group has been seen. A one-bit read strobe returns both flags and clears them in the same cycle.

Top module: `sym_codec`

## Requirements
- R1: After reset, tx_sym is idle 11111, rx_kind is 1 (idle), rx_nib is 0, and both status flags read 0.
- R2: In a data slot, nibbles 0..F are sent as 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Each transmit slot appears on tx_sym one clock edge after it is sampled.
- R3: tx_en seen high while the encoder is idle starts a frame. The next two slots are sent as 11000 then 10001, and the nibbles in those two slots are discarded. Data slots follow.
- R4: tx_en seen low in a data slot ends the frame with 01101 then 00111. Idle 11111 follows while tx_en stays low.
- R5: tx_err high in a data slot with cfg_raw_inv low sends the halt group 00100 instead of the data group.
- R6: tx_err high in a data slot with cfg_raw_inv high sends a raw illegal group. Nibbles 0..9 select, in rising numeric order, 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000, 11001. Nibbles 10..15 select 00000.
- R7: A data group received on rx_sym gives rx_kind 0 and the R2 nibble on rx_nib, one clock edge later.
- R8: Control groups give rx_kind 1 for 11111, 2 for 11000, 3 for 10001, 4 for 01101, 5 for 00111 and 6 for 00100, each with rx_nib 0.
- R9: Any of the ten R6 groups gives rx_kind 7 and rx_nib 0, and sets the invalid flag, which is reg_rdata bit 0.
- R10: Receiving 00100 sets the halt flag, which is reg_rdata bit 1. Other groups leave both flags unchanged.
- R11: reg_rdata shows the flags continuously. A cycle with reg_rd high clears both flags at the next edge.
- R12: When a set event and reg_rd occur in the same cycle, that flag is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Frame enable for the transmit slot |
| tx_err | input | 1 | Transmit error strobe |
| tx_nib | input | 4 | Transmit nibble |
| cfg_raw_inv | input | 1 | Send raw illegal groups on error slots |
| tx_sym | output | 5 | Transmit code group |
| rx_sym | input | 5 | Received code group |
| rx_kind | output | 3 | Class of the received group |
| rx_nib | output | 4 | Decoded receive nibble |
| reg_rd | input | 1 | Status read strobe, clears the flags |
| reg_rdata | output | 2 | Status flags: bit 0 invalid, bit 1 halt |

## Verification
The hardest case to reach is a read of the status flags in the very cycle that a new invalid or halt group arrives. Here the read must report the old value and the flag must still survive the clear. The stimulus first clears the flags with a read. It then drives an illegal group and a halt group, each with reg_rd raised in the same slot, and reads again in the following cycle. On the transmit side, the raw-illegal path is reached only by raising tx_err inside a data slot, past the two-slot start delimiter, with the configuration bit set. The stimulus walks several nibbles through that path, including one of 10 or above.

// File: rtl/codec_pkg.sv
package codec_pkg;
    localparam int NIB_W = 4;
    localparam int SYM_W = 5;
    localparam int KIND_W = 3;

    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
    localparam logic [SYM_W-1:0] SYM_SSD1 = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_SSD2 = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_ESD1 = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_ESD2 = 5'b00111;
    localparam logic [SYM_W-1:0] SYM_HALT = 5'b00100;

    typedef enum logic [KIND_W-1:0] {
        K_DATA = 3'd0, K_IDLE = 3'd1, K_SSD1 = 3'd2, K_SSD2 = 3'd3,
        K_ESD1 = 3'd4, K_ESD2 = 3'd5, K_HALT = 3'd6, K_BAD = 3'd7
    } kind_e;

    function automatic logic [SYM_W-1:0] enc_data(input logic [NIB_W-1:0] n);
        case (n)
            4'h0: enc_data = 5'b11110;  4'h1: enc_data = 5'b01001;
            4'h2: enc_data = 5'b10100;  4'h3: enc_data = 5'b10101;
            4'h4: enc_data = 5'b01010;  4'h5: enc_data = 5'b01011;
            4'h6: enc_data = 5'b01110;  4'h7: enc_data = 5'b01111;
            4'h8: enc_data = 5'b10010;  4'h9: enc_data = 5'b10011;
            4'hA: enc_data = 5'b10110;  4'hB: enc_data = 5'b10111;
            4'hC: enc_data = 5'b11010;  4'hD: enc_data = 5'b11011;
            4'hE: enc_data = 5'b11100;  default: enc_data = 5'b11101;
        endcase
    endfunction

    function automatic logic [SYM_W-1:0] enc_raw(input logic [NIB_W-1:0] n);
        case (n)
            4'h1: enc_raw = 5'b00001;  4'h2: enc_raw = 5'b00010;
            4'h3: enc_raw = 5'b00011;  4'h4: enc_raw = 5'b00101;
            4'h5: enc_raw = 5'b00110;  4'h6: enc_raw = 5'b01000;
            4'h7: enc_raw = 5'b01100;  4'h8: enc_raw = 5'b10000;
            4'h9: enc_raw = 5'b11001;  default: enc_raw = 5'b00000;
        endcase
    endfunction
endpackage

// File: rtl/tx_framer.sv
module tx_framer
    import codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_err,
    input  logic [NIB_W-1:0] tx_nib,
    input  logic             cfg_raw_inv,
    output logic [SYM_W-1:0] tx_sym
);
    typedef enum logic [1:0] {S_IDLE, S_SSD2, S_DATA, S_ESD2} st_e;
    typedef struct packed {
        st_e              st;
        logic [SYM_W-1:0] sym;
    } tx_t;

    tx_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (tx_en) begin
                    r_d.sym = SYM_SSD1;
                    r_d.st  = S_SSD2;
                end else begin
                    r_d.sym = SYM_IDLE;
                end
            end
            S_SSD2: begin
                r_d.sym = SYM_SSD2;
                r_d.st  = S_DATA;
            end
            S_DATA: begin
                if (!tx_en) begin
                    r_d.sym = SYM_ESD1;
                    r_d.st  = S_ESD2;
                end else if (tx_err) begin
                    r_d.sym = cfg_raw_inv ? enc_raw(tx_nib) : SYM_HALT;
                end else begin
                    r_d.sym = enc_data(tx_nib);
                end
            end
            default: begin
                r_d.sym = SYM_ESD2;
                r_d.st  = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= S_IDLE;
            r_q.sym <= SYM_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_sym = r_q.sym;

    AST_SSD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sym == SYM_SSD1 |=> r_q.sym == SYM_SSD2); // R3
    AST_ESD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sym == SYM_ESD1 |=> r_q.sym == SYM_ESD2); // R4
    AST_AFTER_ESD: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sym == SYM_ESD2 |=> (r_q.sym == SYM_IDLE || r_q.sym == SYM_SSD1)); // R4
    AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DATA && tx_en && tx_err && !cfg_raw_inv) |=> r_q.sym == SYM_HALT); // R5
endmodule

// File: rtl/rx_classifier.sv
module rx_classifier
    import codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  rx_sym,
    output logic              hit_bad,
    output logic              hit_halt,
    output logic [KIND_W-1:0] rx_kind,
    output logic [NIB_W-1:0]  rx_nib
);
    typedef struct packed {
        kind_e            kind;
        logic [NIB_W-1:0] nib;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d.kind = K_BAD;
        r_d.nib  = '0;
        for (int i = 0; i < (1 << NIB_W); i++) begin
            if (rx_sym == enc_data(NIB_W'(i))) begin
                r_d.kind = K_DATA;
                r_d.nib  = NIB_W'(i);
            end
        end
        case (rx_sym)
            SYM_IDLE: r_d.kind = K_IDLE;
            SYM_SSD1: r_d.kind = K_SSD1;
            SYM_SSD2: r_d.kind = K_SSD2;
            SYM_ESD1: r_d.kind = K_ESD1;
            SYM_ESD2: r_d.kind = K_ESD2;
            SYM_HALT: r_d.kind = K_HALT;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.kind <= K_IDLE;
            r_q.nib  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hit_bad  = (r_d.kind == K_BAD);
    assign hit_halt = (r_d.kind == K_HALT);
    assign rx_kind  = r_q.kind;
    assign rx_nib   = r_q.nib;

    AST_DATA_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.kind == K_DATA |-> enc_data(r_q.nib) == $past(rx_sym)); // R7
    AST_CTRL_NIB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.kind != K_DATA |-> r_q.nib == '0); // R8
endmodule

// File: rtl/status_flags.sv
module status_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_bad,
    input  logic       set_halt,
    input  logic       rd,
    output logic [1:0] rdata
);
    typedef struct packed {
        logic halt;
        logic bad;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d.bad  = set_bad  | (f_q.bad  & ~rd);
        f_d.halt = set_halt | (f_q.halt & ~rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign rdata = {f_q.halt, f_q.bad};

    AST_SET_WINS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        set_bad |=> rdata[0]); // R12
    AST_SET_WINS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        set_halt |=> rdata[1]); // R12
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !set_bad && !set_halt) |=> rdata == 2'b00); // R11
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && rdata[0]) |=> rdata[0]); // R9
endmodule

// File: rtl/sym_codec.sv
module sym_codec
    import codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_err,
    input  logic [NIB_W-1:0]  tx_nib,
    input  logic              cfg_raw_inv,
    output logic [SYM_W-1:0]  tx_sym,
    input  logic [SYM_W-1:0]  rx_sym,
    output logic [KIND_W-1:0] rx_kind,
    output logic [NIB_W-1:0]  rx_nib,
    input  logic              reg_rd,
    output logic [1:0]        reg_rdata
);
    logic hit_bad, hit_halt;

    tx_framer u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_err(tx_err),
        .tx_nib(tx_nib), .cfg_raw_inv(cfg_raw_inv), .tx_sym(tx_sym)
    );

    rx_classifier u_rx (
        .clk(clk), .rst_n(rst_n), .rx_sym(rx_sym), .hit_bad(hit_bad),
        .hit_halt(hit_halt), .rx_kind(rx_kind), .rx_nib(rx_nib)
    );

    status_flags u_st (
        .clk(clk), .rst_n(rst_n), .set_bad(hit_bad), .set_halt(hit_halt),
        .rd(reg_rd), .rdata(reg_rdata)
    );

    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_kind == 3'd7 |-> reg_rdata[0]); // R9
    AST_HALT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_kind == 3'd6 |-> reg_rdata[1]); // R10
endmodule

// File: tb/sym_codec_tb_top.sv
module sym_codec_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_err = 1'b0, cfg_raw_inv = 1'b0, reg_rd = 1'b0;
    logic [3:0] tx_nib = 4'h0;
    logic [4:0] rx_sym = 5'b11111;
    logic [4:0] tx_sym;
    logic [2:0] rx_kind;
    logic [3:0] rx_nib;
    logic [1:0] reg_rdata;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    logic [4:0]  q_tx[$];
    logic [6:0]  q_rx[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    sym_codec dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_err(tx_err),
        .tx_nib(tx_nib), .cfg_raw_inv(cfg_raw_inv), .tx_sym(tx_sym),
        .rx_sym(rx_sym), .rx_kind(rx_kind), .rx_nib(rx_nib),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    localparam logic [4:0] D_TAB [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
        5'b01010, 5'b01011, 5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110,
        5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
    localparam logic [4:0] BAD_TAB [10] = '{5'b00000, 5'b00001, 5'b00010,
        5'b00011, 5'b00101, 5'b00110, 5'b01000, 5'b01100, 5'b10000, 5'b11001};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one slot, pushes the expected transmit and receive results.
    task automatic slot(input logic en, input logic err, input logic [3:0] nib,
                        input logic [4:0] rs, input logic [4:0] etx,
                        input logic [2:0] ekind, input logic [3:0] enib, input string tag);
        @(negedge clk);
        tx_en = en; tx_err = err; tx_nib = nib; rx_sym = rs; reg_rd = 1'b0;
        q_tx.push_back(etx);
        q_rx.push_back({ekind, enib});
        q_tag.push_back(tag);
    endtask

    // Monitor: pops one expected item per edge once the driver has pushed one.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_tx.size() > 0) begin
                logic [4:0] et;
                logic [6:0] er;
                string tg;
                et = q_tx.pop_front();
                er = q_rx.pop_front();
                tg = q_tag.pop_front();
                check({tg, " tx"}, {3'b0, tx_sym}, {3'b0, et});
                check({tg, " rx"}, {1'b0, rx_kind, rx_nib}, {1'b0, er});
            end
        end
    end

    task automatic flag_cycle(input logic rd, input logic [4:0] rs,
                              input logic [1:0] exp, input string tag);
        @(negedge clk);
        tx_en = 1'b0; tx_err = 1'b0; reg_rd = rd; rx_sym = rs;
        check(tag, {6'b0, reg_rdata}, {6'b0, exp});
    endtask

    function automatic logic [2:0] bench_kind(input logic [4:0] s);
        case (s)
            5'b11111: return 3'd1;  5'b11000: return 3'd2;
            5'b10001: return 3'd3;  5'b01101: return 3'd4;
            5'b00111: return 3'd5;  5'b00100: return 3'd6;
            default: begin
                for (int i = 0; i < 16; i++) if (D_TAB[i] == s) return 3'd0;
                return 3'd7;
            end
        endcase
    endfunction

    function automatic logic [3:0] bench_nib(input logic [4:0] s);
        for (int i = 0; i < 16; i++) if (D_TAB[i] == s) return 4'(i);
        return 4'h0;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 tx_sym", {3'b0, tx_sym}, 8'h1F);
        check("R1 rx_kind", {5'b0, rx_kind}, 8'd1);
        check("R1 rx_nib", {4'b0, rx_nib}, 8'd0);
        check("R1 flags", {6'b0, reg_rdata}, 8'd0);
        rst_n = 1'b1;

        // R3 frame start, R2 data, R4 end, idle after
        slot(1, 0, 4'h5, 5'b11111, 5'b11000, 3'd1, 4'h0, "R3 ssd1");
        slot(1, 0, 4'h6, 5'b11111, 5'b10001, 3'd1, 4'h0, "R3 ssd2");
        for (int i = 0; i < 16; i++)
            slot(1, 0, 4'(i), 5'b11111, D_TAB[i], 3'd1, 4'h0, "R2 data");
        slot(0, 0, 4'h3, 5'b11111, 5'b01101, 3'd1, 4'h0, "R4 esd1");
        slot(0, 0, 4'h3, 5'b11111, 5'b00111, 3'd1, 4'h0, "R4 esd2");
        slot(0, 0, 4'h3, 5'b11111, 5'b11111, 3'd1, 4'h0, "R4 idle");
        slot(0, 1, 4'h3, 5'b11111, 5'b11111, 3'd1, 4'h0, "R4 idle err");

        // R5 halt on error, R6 raw illegal groups
        slot(1, 0, 4'h0, 5'b11111, 5'b11000, 3'd1, 4'h0, "R3 ssd1 b");
        slot(1, 1, 4'h0, 5'b11111, 5'b10001, 3'd1, 4'h0, "R3 ssd2 err ignored");
        slot(1, 1, 4'h7, 5'b11111, 5'b00100, 3'd1, 4'h0, "R5 halt");
        slot(1, 0, 4'h7, 5'b11111, 5'b01111, 3'd1, 4'h0, "R2 after halt");
        cfg_raw_inv = 1'b1;
        for (int i = 0; i < 16; i++)
            slot(1, 1, 4'(i), 5'b11111, (i < 10) ? BAD_TAB[i] : 5'b00000,
                 3'd1, 4'h0, "R6 raw");
        slot(1, 0, 4'hA, 5'b11111, 5'b10110, 3'd1, 4'h0, "R6 data unaffected");
        slot(0, 0, 4'h0, 5'b11111, 5'b01101, 3'd1, 4'h0, "R4 esd1 b");
        cfg_raw_inv = 1'b0;
        slot(1, 0, 4'h0, 5'b11111, 5'b00111, 3'd1, 4'h0, "R4 esd2 b");
        slot(1, 0, 4'h1, 5'b11111, 5'b11000, 3'd1, 4'h0, "R4 restart");
        slot(0, 0, 4'h1, 5'b11111, 5'b10001, 3'd1, 4'h0, "R3 ssd2 c");
        slot(0, 0, 4'h1, 5'b11111, 5'b01101, 3'd1, 4'h0, "R4 esd1 c");
        slot(0, 0, 4'h1, 5'b11111, 5'b00111, 3'd1, 4'h0, "R4 esd2 c");

        // R7 R8 R9: receive every group
        for (int s = 0; s < 32; s++)
            slot(0, 0, 4'h0, 5'(s), 5'b11111, bench_kind(5'(s)), bench_nib(5'(s)),
                 "R7 R8 R9 rx");
        slot(0, 0, 4'h0, 5'b11111, 5'b11111, 3'd1, 4'h0, "R8 idle");
        @(negedge clk);
        // R9 R10: both flags were set by the sweep above
        flag_cycle(1, 5'b11111, 2'b11, "R9 R10 flags set");
        flag_cycle(0, 5'b11111, 2'b00, "R11 cleared");
        // R10: data and control groups set nothing
        flag_cycle(0, 5'b01001, 2'b00, "R10 no set");
        flag_cycle(0, 5'b11000, 2'b00, "R10 no set ctl");
        flag_cycle(0, 5'b00100, 2'b00, "R10 before halt");
        flag_cycle(0, 5'b11111, 2'b10, "R10 halt set");
        flag_cycle(0, 5'b11001, 2'b10, "R10 halt sticky");
        flag_cycle(0, 5'b11111, 2'b11, "R9 bad set");
        flag_cycle(0, 5'b11111, 2'b11, "R9 sticky");
        flag_cycle(1, 5'b00101, 2'b11, "R11 read shows old");
        flag_cycle(0, 5'b11111, 2'b01, "R12 bad set wins");
        flag_cycle(1, 5'b00100, 2'b01, "R11 read b");
        flag_cycle(1, 5'b11111, 2'b10, "R12 halt set wins");
        flag_cycle(0, 5'b11111, 2'b00, "R11 cleared b");
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule